// File: doc/BRIEF.md
# Frequency-Voltage Halt Sequencer

This block orders the operating-point changes around the core's low-power halt state. When an enter request arrives in normal operation, it saves the present core ratio and supply voltage code. It then lowers the ratio first and drops the voltage code only after the ratio actuator reports completion. A break event (interrupt, init or reset-class) runs the mirror order: the voltage code is raised back to its saved value first, and the saved ratio is restored only after the voltage actuator reports completion. At every step the supply therefore stays high enough for the clock the core is running at.

Each actuator sees a command value and a request level. The request stays high, and the value stays fixed, until the actuator answers with a one-cycle done pulse. Only one actuator is busy at any time. The bus clock is not touched; only the core-to-bus ratio moves. Snoops served in the low state have no path into this block, so they leave the low operating point in place.

Top module: `fv_halt_seq`

## Requirements
- R1: After reset both request outputs, both command outputs and the low-point flag are 0, and the block is in normal operation.
- R2: An enter request accepted in normal operation issues the low ratio on the ratio port first. The voltage request stays low until that ratio command is done.
- R3: The done pulse of the entry ratio command issues the low voltage code on the voltage port.
- R4: The low-point flag rises only after both low values are applied. It falls in the same cycle that the first exit command is issued, and it is never high while a request is outstanding.
- R5: A break event in the low state issues the saved voltage code first. After that command is done, it issues the saved ratio, and after that one is done the block returns to normal operation.
- R6: The values restored on exit are the ratio and voltage inputs sampled in the cycle the enter request was accepted, whatever those inputs do afterwards.
- R7: At most one request is high at a time. A command value stays unchanged and its request stays high until its done pulse.
- R8: A break event during the entry ratio step lets that step finish, then issues the saved ratio directly. No voltage command is issued.
- R9: A break event during the entry voltage step lets that step finish, then restores the voltage and then the ratio. The low-point flag does not rise.
- R10: A break event in normal operation, and an enter request while a sequence is running, have no effect.
- R11: A break event that coincides with the done pulse of an entry step is honoured exactly as in R8 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enter_req_i | input | 1 | Request to enter the low state |
| break_i | input | 1 | Break event, requests exit |
| norm_ratio_i | input | RATIO_W | Present core ratio, saved on entry |
| norm_vid_i | input | VID_W | Present voltage code, saved on entry |
| low_ratio_i | input | RATIO_W | Ratio used in the low state |
| low_vid_i | input | VID_W | Voltage code used in the low state |
| ratio_done_i | input | 1 | Ratio actuator completion pulse |
| vid_done_i | input | 1 | Voltage actuator completion pulse |
| ratio_req_o | output | 1 | Ratio command outstanding |
| ratio_cmd_o | output | RATIO_W | Ratio command value |
| vid_req_o | output | 1 | Voltage command outstanding |
| vid_cmd_o | output | VID_W | Voltage command value |
| low_point_o | output | 1 | Low operating point reached |

## Verification
A break event can fall in the same cycle as an actuator done pulse during entry. The block must then finish that step and branch straight into the exit order. The bench provokes this by watching for the ratio done pulse and raising the break in that same cycle. It judges the result by the order of the commands the actuators complete, which must be low ratio followed by saved ratio with no voltage step. Actuator latencies are randomized, and breaks also arrive in mid-step and after the low point is reached, so the recorded command order is compared against the order predicted for each case.

// File: rtl/fvh_pkg.sv
package fvh_pkg;
  typedef enum logic [2:0] {
    ST_NORM      = 3'd0,
    ST_ENT_RATIO = 3'd1,
    ST_ENT_VID   = 3'd2,
    ST_LOW       = 3'd3,
    ST_EXT_VID   = 3'd4,
    ST_EXT_RATIO = 3'd5
  } fvh_state_e;
endpackage

// File: rtl/fvh_capture.sv
module fvh_capture #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/fvh_cmd_reg.sv
module fvh_cmd_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         issue_i,
  input  logic [W-1:0] val_i,
  input  logic         done_i,
  output logic         req_o,
  output logic [W-1:0] cmd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      cmd_o <= '0;
    end else if (issue_i) begin
      req_o <= 1'b1;
      cmd_o <= val_i;
    end else if (done_i) begin
      req_o <= 1'b0;
    end
  end

  assert_cmd_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !done_i) |=> (req_o && $stable(cmd_o)));
  assert_no_reissue_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> (!req_o || done_i));
endmodule

// File: rtl/fvh_ctrl.sv
module fvh_ctrl
  import fvh_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic break_i,
  input  logic ratio_done_i,
  input  logic vid_done_i,
  input  logic ratio_busy_i,
  input  logic vid_busy_i,
  output logic capture_o,
  output logic ratio_issue_o,
  output logic ratio_low_o,
  output logic vid_issue_o,
  output logic vid_low_o,
  output logic low_point_o
);
  fvh_state_e state_q, state_d;
  logic pend_q, pend_d;
  logic r_done, v_done, brk, in_ent_q, in_ent_d;

  assign r_done   = ratio_done_i & ratio_busy_i;
  assign v_done   = vid_done_i & vid_busy_i;
  assign brk      = pend_q | break_i;
  assign in_ent_q = (state_q == ST_ENT_RATIO) || (state_q == ST_ENT_VID);
  assign in_ent_d = (state_d == ST_ENT_RATIO) || (state_d == ST_ENT_VID);

  always_comb begin
    state_d       = state_q;
    capture_o     = 1'b0;
    ratio_issue_o = 1'b0;
    ratio_low_o   = 1'b0;
    vid_issue_o   = 1'b0;
    vid_low_o     = 1'b0;
    unique case (state_q)
      ST_NORM: if (enter_i) begin
        capture_o     = 1'b1;
        ratio_issue_o = 1'b1;
        ratio_low_o   = 1'b1;
        state_d       = ST_ENT_RATIO;
      end
      ST_ENT_RATIO: if (r_done) begin
        if (brk) begin
          ratio_issue_o = 1'b1;        // voltage never moved: skip its restore
          state_d       = ST_EXT_RATIO;
        end else begin
          vid_issue_o = 1'b1;
          vid_low_o   = 1'b1;
          state_d     = ST_ENT_VID;
        end
      end
      ST_ENT_VID: if (v_done) begin
        if (brk) begin
          vid_issue_o = 1'b1;
          state_d     = ST_EXT_VID;
        end else begin
          state_d = ST_LOW;
        end
      end
      ST_LOW: if (break_i) begin
        vid_issue_o = 1'b1;
        state_d     = ST_EXT_VID;
      end
      ST_EXT_VID: if (v_done) begin
        ratio_issue_o = 1'b1;
        state_d       = ST_EXT_RATIO;
      end
      ST_EXT_RATIO: if (r_done) state_d = ST_NORM;
      default: state_d = ST_NORM;
    endcase
  end

  // break seen during entry is held until the running step completes
  assign pend_d = (in_ent_q && in_ent_d) ? brk : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORM;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign low_point_o = (state_q == ST_LOW);

  assert_one_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ratio_busy_i && vid_busy_i));
  assert_low_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_point_o |-> (!ratio_busy_i && !vid_busy_i));
  assert_entry_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENT_RATIO) |-> !vid_busy_i);
  assert_exit_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXT_VID) |-> !ratio_busy_i);
  assert_low_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_point_o && break_i) |=> (!low_point_o && vid_busy_i));
  assert_norm_break_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NORM && !enter_i) |=> (state_q == ST_NORM));
endmodule

// File: rtl/fv_halt_seq.sv
module fv_halt_seq #(
  parameter int RATIO_W = 6,
  parameter int VID_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enter_req_i,
  input  logic               break_i,
  input  logic [RATIO_W-1:0] norm_ratio_i,
  input  logic [VID_W-1:0]   norm_vid_i,
  input  logic [RATIO_W-1:0] low_ratio_i,
  input  logic [VID_W-1:0]   low_vid_i,
  input  logic               ratio_done_i,
  input  logic               vid_done_i,
  output logic               ratio_req_o,
  output logic [RATIO_W-1:0] ratio_cmd_o,
  output logic               vid_req_o,
  output logic [VID_W-1:0]   vid_cmd_o,
  output logic               low_point_o
);
  logic capture, ratio_issue, ratio_low, vid_issue, vid_low;
  logic [RATIO_W-1:0] saved_ratio, ratio_val;
  logic [VID_W-1:0]   saved_vid, vid_val;

  fvh_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enter_i      (enter_req_i),
    .break_i      (break_i),
    .ratio_done_i (ratio_done_i),
    .vid_done_i   (vid_done_i),
    .ratio_busy_i (ratio_req_o),
    .vid_busy_i   (vid_req_o),
    .capture_o    (capture),
    .ratio_issue_o(ratio_issue),
    .ratio_low_o  (ratio_low),
    .vid_issue_o  (vid_issue),
    .vid_low_o    (vid_low),
    .low_point_o  (low_point_o)
  );

  fvh_capture #(.W(RATIO_W)) u_cap_ratio (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(capture), .d_i(norm_ratio_i), .q_o(saved_ratio)
  );
  fvh_capture #(.W(VID_W)) u_cap_vid (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(capture), .d_i(norm_vid_i), .q_o(saved_vid)
  );

  assign ratio_val = ratio_low ? low_ratio_i : saved_ratio;
  assign vid_val   = vid_low   ? low_vid_i   : saved_vid;

  fvh_cmd_reg #(.W(RATIO_W)) u_ratio_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(ratio_issue), .val_i(ratio_val),
    .done_i(ratio_done_i), .req_o(ratio_req_o), .cmd_o(ratio_cmd_o)
  );
  fvh_cmd_reg #(.W(VID_W)) u_vid_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(vid_issue), .val_i(vid_val),
    .done_i(vid_done_i), .req_o(vid_req_o), .cmd_o(vid_cmd_o)
  );
endmodule

// File: tb/fv_halt_seq_bench.sv
`timescale 1ns/1ps
module fv_halt_seq_bench;
  localparam int RW = 6;
  localparam int VW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enter = 1'b0, brk = 1'b0;
  logic [RW-1:0] norm_r = '0, low_r = '0;
  logic [VW-1:0] norm_v = '0, low_v = '0;
  logic r_done = 1'b0, v_done = 1'b0;
  logic r_req, v_req, low_pt;
  logic [RW-1:0] r_cmd;
  logic [VW-1:0] v_cmd;

  int total = 0, bad = 0, cyc = 0;
  int lat_r = 2, lat_v = 2;
  int r_cnt = 0, v_cnt = 0;
  logic r_busy = 1'b0, v_busy = 1'b0;
  int log_k[$];
  int log_v[$];
  int inv_bad = 0;
  logic prev_r_req = 1'b0, prev_v_req = 1'b0, prev_r_done = 1'b0, prev_v_done = 1'b0;
  logic [RW-1:0] prev_r_cmd = '0;
  logic [VW-1:0] prev_v_cmd = '0;
  logic low_seen = 1'b0;

  always #2.5 clk = ~clk;

  fv_halt_seq u_fv_halt_seq (
    .clk_i(clk), .rst_ni(rst_n), .enter_req_i(enter), .break_i(brk),
    .norm_ratio_i(norm_r), .norm_vid_i(norm_v), .low_ratio_i(low_r), .low_vid_i(low_v),
    .ratio_done_i(r_done), .vid_done_i(v_done),
    .ratio_req_o(r_req), .ratio_cmd_o(r_cmd), .vid_req_o(v_req), .vid_cmd_o(v_cmd),
    .low_point_o(low_pt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // actuator models with programmable latency
  always @(negedge clk) begin
    r_done <= 1'b0;
    v_done <= 1'b0;
    if (r_req && !r_busy) begin r_busy <= 1'b1; r_cnt <= lat_r; end
    else if (r_busy) begin
      if (r_cnt == 0) begin r_done <= 1'b1; r_busy <= 1'b0; end
      else r_cnt <= r_cnt - 1;
    end
    if (v_req && !v_busy) begin v_busy <= 1'b1; v_cnt <= lat_v; end
    else if (v_busy) begin
      if (v_cnt == 0) begin v_done <= 1'b1; v_busy <= 1'b0; end
      else v_cnt <= v_cnt - 1;
    end
  end

  // monitor: completed commands and invariants
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (r_req && r_done) begin log_k.push_back(0); log_v.push_back(int'(r_cmd)); end
      if (v_req && v_done) begin log_k.push_back(1); log_v.push_back(int'(v_cmd)); end
      if (r_req && v_req) begin
        inv_bad++; $display("FAIL R7 both requests high actual=1 expected=0");
      end
      if (prev_r_req && !prev_r_done && (!r_req || r_cmd != prev_r_cmd)) begin
        inv_bad++; $display("FAIL R7 ratio cmd actual=%0d expected=%0d", r_cmd, prev_r_cmd);
      end
      if (prev_v_req && !prev_v_done && (!v_req || v_cmd != prev_v_cmd)) begin
        inv_bad++; $display("FAIL R7 vid cmd actual=%0d expected=%0d", v_cmd, prev_v_cmd);
      end
      if (low_pt && (r_req || v_req)) begin
        inv_bad++; $display("FAIL R4 low flag with request actual=1 expected=0");
      end
      if (low_pt) low_seen = 1'b1;
    end
    prev_r_req = r_req; prev_v_req = v_req;
    prev_r_done = r_done; prev_v_done = v_done;
    prev_r_cmd = r_cmd; prev_v_cmd = v_cmd;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int exp_len(input int kind);
    return (kind == 1 || kind == 3) ? 2 : 4;
  endfunction
  function automatic int exp_k(input int kind, input int i);
    if (kind == 1 || kind == 3) return 0;
    return (i == 0 || i == 3) ? 0 : 1;
  endfunction
  function automatic int exp_v(input int kind, input int i, input int sr, input int sv,
                               input int lr, input int lv);
    if (kind == 1 || kind == 3) return (i == 0) ? lr : sr;
    case (i)
      0: return lr;
      1: return lv;
      2: return sv;
      default: return sr;
    endcase
  endfunction

  task automatic wait_until_rreq();
    for (int i = 0; i < 50 && !r_req; i++) @(negedge clk);
  endtask

  // kind: 0 full, 1 break in ratio step, 2 break in vid step, 3 break with ratio done
  task automatic scenario(input int kind, input string tag);
    int sr, sv, lr, lv;
    logic [RW-1:0] tmp_r;
    logic [VW-1:0] tmp_v;
    lat_r = $urandom_range(0, 9);
    lat_v = $urandom_range(0, 9);
    log_k.delete(); log_v.delete();
    low_seen = 1'b0;
    tmp_r = RW'($urandom); tmp_v = VW'($urandom);
    sr = int'(tmp_r); sv = int'(tmp_v);
    norm_r = tmp_r; norm_v = tmp_v;
    tmp_r = RW'($urandom); tmp_v = VW'($urandom);
    lr = int'(tmp_r); lv = int'(tmp_v);
    low_r = tmp_r; low_v = tmp_v;
    @(negedge clk); enter = 1'b1;
    @(negedge clk); enter = 1'b0;
    norm_r = RW'($urandom); norm_v = VW'($urandom);   // R6: later input changes
    #1;
    check(r_req && !v_req && int'(r_cmd) == lr, "R2 low ratio first", int'(r_cmd), lr);
    case (kind)
      0: begin
        for (int i = 0; i < 60 && !low_pt; i++) @(negedge clk);
        #1;
        check(low_pt && int'(r_cmd) == lr && int'(v_cmd) == lv, "R4 low point after both",
              int'(v_cmd), lv);
        repeat ($urandom_range(1, 4)) @(negedge clk);
        brk = 1'b1;
        @(negedge clk); brk = 1'b0;
        #1;
        check(!low_pt && v_req && int'(v_cmd) == sv, "R4 R5 first exit step", int'(v_cmd), sv);
      end
      1: begin
        @(negedge clk); brk = 1'b1; enter = 1'b1;   // R10: enter while busy ignored
        @(negedge clk); brk = 1'b0; enter = 1'b0;
      end
      2: begin
        for (int i = 0; i < 60 && !v_req; i++) @(negedge clk);
        brk = 1'b1;
        @(negedge clk); brk = 1'b0;
      end
      default: begin
        for (int i = 0; i < 60 && !r_done; i++) begin @(negedge clk); #1; end
        brk = 1'b1;                                  // R11: same cycle as done
        @(negedge clk); brk = 1'b0;
      end
    endcase
    repeat (50) @(negedge clk);
    #1;
    check(!r_req && !v_req && !low_pt, {tag, " back to normal"}, int'(r_req | v_req), 0);
    check(log_k.size() == exp_len(kind), {tag, " step count"}, log_k.size(), exp_len(kind));
    if (log_k.size() == exp_len(kind)) begin
      for (int i = 0; i < exp_len(kind); i++) begin
        check(log_k[i] == exp_k(kind, i), {tag, " R6 actuator order"}, log_k[i], exp_k(kind, i));
        check(log_v[i] == exp_v(kind, i, sr, sv, lr, lv), {tag, " R6 value"}, log_v[i],
              exp_v(kind, i, sr, sv, lr, lv));
      end
    end
    if (kind != 0) check(!low_seen, {tag, " R9 no low flag on abort"}, int'(low_seen), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    check(!r_req && !v_req && !low_pt && r_cmd == '0 && v_cmd == '0, "R1 reset state",
          int'(r_req | v_req | low_pt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: break in normal operation ignored
    log_k.delete();
    brk = 1'b1;
    @(negedge clk); brk = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    check(!r_req && !v_req && !low_pt && log_k.size() == 0, "R10 break in normal",
          log_k.size(), 0);
    scenario(0, "R3 R5 full");
    scenario(1, "R8 break in ratio");
    scenario(2, "R9 break in vid");
    scenario(3, "R11 break at done");
    for (int n = 0; n < 40; n++) begin
      int k;
      k = $urandom_range(0, 3);
      scenario(k, "R7 random");
    end
    check(inv_bad == 0, "R7 R4 invariants", inv_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule